// File: doc/BRIEF.md
# Insert-Character-and-Count Execution Unit

This unit executes one byte-insert-with-post-increment instruction for a small 16-bit processor. When started, it takes three instruction fields: an address-register selector, a pair selector and a byte-lane selector. It also takes the index of the active register group. The unit reads the address register and sends a one-byte storage read to the address that register holds. It writes the address plus one back into the same register. It then merges the returned byte into one half of the odd member of the selected register pair.

The register file and the storage array sit outside the unit. The unit has one combinational read port and one write port into the register file. It has a byte-wide storage read port whose data arrives one cycle after the request. A start strobe launches the instruction, and a done strobe marks its final cycle.

The controller has three states. `ST_IDLE` waits for a start and moves to `ST_I1` on a start. `ST_I1` performs the address read, the storage request and the increment write-back, then always moves to `ST_I2`. `ST_I2` performs the byte merge and target write, pulses done, then always returns to `ST_IDLE`.

Top module: `ict_exec_unit`

## Requirements
- R1: A start seen in `ST_IDLE` is followed by exactly two busy cycles. In the first, done is 0. In the second, done is 1. Done stays high for one cycle only.
- R2: The target register index inside the group is 2×`r_field`+1. Its bit 0 is always 1.
- R3: In the first busy cycle, `mem_re` is 1 and `mem_addr` equals the value read from the register named by `b_field`.
- R4: In the first busy cycle, the register named by `b_field` is written with its value plus one, wrapping modulo 2^16 (0xFFFF becomes 0x0000).
- R5: With `n_field`=0, the fetched byte replaces bits 15:8 of the target, and bits 7:0 keep their prior value.
- R6: With `n_field`=1, the fetched byte replaces bits 7:0 of the target, and bits 15:8 keep their prior value.
- R7: When the address register and the target are the same register, the increment lands first and the insert second. With N=1 the result is {high byte of (old+1), fetched byte}. With N=0 it is {fetched byte, low byte of (old+1)}.
- R8: Every register-file address is {group, index}, using the group sampled at start. Registers of other groups are never written.
- R9: Start and all field and group inputs are ignored while the unit is busy. The executed instruction uses the values sampled at the accepted start.
- R10: After reset the unit is idle, with done, `rf_we` and `mem_re` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| b_field | input | 3 | Address-register index |
| r_field | input | 2 | Register-pair index; the target is 2×r+1 |
| n_field | input | 1 | Byte lane: 0 = bits 15:8, 1 = bits 7:0 |
| grp_sel | input | 1 | Active register group |
| rf_rd_addr | output | 4 | Register-file read address {group, index} |
| rf_rd_data | input | 16 | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_addr | output | 4 | Register-file write address {group, index} |
| rf_wr_data | output | 16 | Register-file write data |
| mem_re | output | 1 | Storage byte read request |
| mem_addr | output | 16 | Storage byte address |
| mem_rdata | input | 8 | Storage byte, valid the cycle after the request |
| done | output | 1 | High in the last execution cycle |

## Verification
The assertions assume the following about the surroundings:
- The register file returns, in the same cycle, the data at the address the unit drives.
- A write becomes visible to the next cycle's read.
- Storage returns its byte exactly one cycle after the request.

The bench models both neighbours with exactly these timings. It applies stimulus only on falling edges, so no input moves near the sampling edge. To exercise the ignore rules, it deliberately toggles start, the fields and the group while the unit is busy.

// File: rtl/ict_pkg.sv
package ict_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_I1   = 2'd1,
        ST_I2   = 2'd2
    } ict_state_e;
endpackage

// File: rtl/ict_ctrl.sv
module ict_ctrl
    import ict_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output ict_state_e state_o,
    output logic       accept_o,
    output logic       in_i1_o,
    output logic       in_i2_o
);
    ict_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_I1;
            ST_I1:   state_d = ST_I2;
            ST_I2:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        accept_o = 1'b0;
        in_i1_o  = 1'b0;
        in_i2_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = start;
            ST_I1:   in_i1_o  = 1'b1;
            ST_I2:   in_i2_o  = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/ict_byte_merge.sv
module ict_byte_merge #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [SEL_W-1:0]  lane_i,
    output logic [DATA_W-1:0] merged_o
);
    // lane 0 is the most significant byte
    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        localparam int HI = DATA_W - 1 - j * BYTE_W;
        assign merged_o[HI -: BYTE_W] =
            (lane_i == SEL_W'(j)) ? byte_i : base_i[HI -: BYTE_W];
    end
endmodule

// File: rtl/ict_exec_unit.sv
module ict_exec_unit
    import ict_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GRP_REGS = 8,
    parameter int NUM_GRP = 2,
    localparam int BYTE_W = 8,
    localparam int IDX_W  = $clog2(GRP_REGS),
    localparam int R_W    = IDX_W - 1,
    localparam int GRP_W  = $clog2(NUM_GRP),
    localparam int RF_AW  = GRP_W + IDX_W,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  b_field,
    input  logic [R_W-1:0]    r_field,
    input  logic [SEL_W-1:0]  n_field,
    input  logic [GRP_W-1:0]  grp_sel,
    output logic [RF_AW-1:0]  rf_rd_addr,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_wr_addr,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done
);
    ict_state_e       state_q;
    logic             accept, in_i1, in_i2;
    logic [IDX_W-1:0] b_q;
    logic [R_W-1:0]   r_q;
    logic [SEL_W-1:0] n_q;
    logic [GRP_W-1:0] grp_q;
    logic [IDX_W-1:0] tgt_idx;
    logic [DATA_W-1:0] merged;

    ict_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .state_o  (state_q),
        .accept_o (accept),
        .in_i1_o  (in_i1),
        .in_i2_o  (in_i2)
    );

    // instruction fields sampled once per accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q   <= '0;
            r_q   <= '0;
            n_q   <= '0;
            grp_q <= '0;
        end else if (accept) begin
            b_q   <= b_field;
            r_q   <= r_field;
            n_q   <= n_field;
            grp_q <= grp_sel;
        end
    end

    // odd member of the selected pair
    assign tgt_idx = {r_q, 1'b1};

    ict_byte_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
        .base_i   (rf_rd_data),
        .byte_i   (mem_rdata),
        .lane_i   (n_q),
        .merged_o (merged)
    );

    // per-cycle datapath controls
    always_comb begin
        rf_rd_addr = {grp_q, b_q};
        rf_we      = 1'b0;
        rf_wr_addr = {grp_q, b_q};
        rf_wr_data = '0;
        mem_re     = 1'b0;
        mem_addr   = '0;
        done       = 1'b0;
        if (in_i1) begin
            mem_re     = 1'b1;
            mem_addr   = rf_rd_data;
            rf_we      = 1'b1;
            rf_wr_data = rf_rd_data + DATA_W'(1);
        end else if (in_i2) begin
            rf_rd_addr = {grp_q, tgt_idx};
            rf_we      = 1'b1;
            rf_wr_addr = {grp_q, tgt_idx};
            rf_wr_data = merged;
            done       = 1'b1;
        end
    end
endmodule

// File: rtl/ict_exec_checker.sv
module ict_exec_checker
    import ict_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RF_AW  = 4,
    parameter int SEL_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input ict_state_e        state_q,
    input logic              mem_re,
    input logic              rf_we,
    input logic [RF_AW-1:0]  rf_rd_addr,
    input logic [RF_AW-1:0]  rf_wr_addr,
    input logic [DATA_W-1:0] rf_rd_data,
    input logic [DATA_W-1:0] rf_wr_data,
    input logic [SEL_W-1:0]  n_q
);
    // R1: accepted start gives one quiet cycle, then done
    a_r1_done_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |=> (!done ##1 done));

    // R1: done is a single-cycle pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the final write always targets an odd register
    a_r2_odd_target: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rf_we && rf_wr_addr[0]));

    // R4: a storage request coincides with the increment write to the read register
    a_r4_incr_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (rf_we && rf_wr_addr == rf_rd_addr
                    && rf_wr_data == rf_rd_data + DATA_W'(1)));

    // R3: the storage request is followed by the completion cycle
    a_r3_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> done);

    // R5: lane 0 insert keeps the low byte of the target
    a_r5_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && n_q == '0) |-> (rf_wr_data[DATA_W-9:0] == rf_rd_data[DATA_W-9:0]));
endmodule

bind ict_exec_unit ict_exec_checker #(
    .DATA_W (DATA_W),
    .RF_AW  (RF_AW),
    .SEL_W  (SEL_W)
) u_chk (.*);

// File: tb/ict_exec_unit_bench.sv
module ict_exec_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  b_field = '0;
    logic [1:0]  r_field = '0;
    logic        n_field = 1'b0;
    logic        grp_sel = 1'b0;
    logic [3:0]  rf_rd_addr, rf_wr_addr;
    logic [15:0] rf_rd_data, rf_wr_data, mem_addr;
    logic        rf_we, mem_re, done;
    logic [7:0]  mem_rdata;

    int total = 0;
    int bad = 0;

    logic [15:0] rf [16];
    logic [15:0] pre [16];
    logic        pl_we = 1'b0;
    logic [3:0]  pl_idx = '0;
    logic [15:0] pl_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ict_exec_unit u_ict_exec_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .b_field(b_field),
        .r_field(r_field), .n_field(n_field), .grp_sel(grp_sel),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
        .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done)
    );

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // register file and storage models
    assign rf_rd_data = rf[rf_rd_addr];
    always @(posedge clk) begin
        if (pl_we) rf[pl_idx] <= pl_data;
        else if (rf_we) rf[rf_wr_addr] <= rf_wr_data;
        if (mem_re) mem_rdata <= mem_fn(mem_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input int seed);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            pl_we = 1'b1;
            pl_idx = 4'(k);
            pl_data = 16'(seed * 16'h9E37 + k * 16'h1111);
            if (seed % 5 == 0 && k[2:0] == 3'(seed % 8)) pl_data = 16'hFFFF;
            pre[k] = pl_data;
        end
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic run_instr(input logic g, input logic [2:0] b, input logic [1:0] r,
                             input logic n, input bit poke);
        logic [3:0]  ba, ta, oa;
        logic [15:0] bval, bnew, tbase, texp;
        logic [7:0]  byt;
        ba = {g, b};
        ta = {g, r, 1'b1};
        oa = {~g, b};
        bval = pre[ba];
        bnew = bval + 16'd1;
        byt = mem_fn(bval);
        tbase = (ba == ta) ? bnew : pre[ta];
        texp = n ? {tbase[15:8], byt} : {byt, tbase[7:0]};
        @(negedge clk);
        grp_sel = g; b_field = b; r_field = r; n_field = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_re && mem_addr == bval, "R3 storage address", mem_addr, bval);
        chk(!done, "R1 done low in first cycle", 16'(done), 16'd0);
        if (poke) begin // R9: inputs toggled while busy
            start = 1'b1; grp_sel = ~g; b_field = ~b; r_field = ~r; n_field = ~n;
        end
        @(negedge clk);
        start = 1'b0;
        chk(done, "R1 done high in second cycle", 16'(done), 16'd1);
        @(negedge clk);
        chk(!done && !rf_we, "R1 R9 idle after done", 16'(done), 16'd0);
        if (ba != ta)
            chk(rf[ba] == bnew, "R4 address increment", rf[ba], bnew);
        chk(rf[ta] == texp, n ? (ba == ta ? "R7 same reg lane1" : "R6 low byte insert")
                              : (ba == ta ? "R7 same reg lane0" : "R5 high byte insert"),
            rf[ta], texp);
        chk(rf[oa] == pre[oa], "R8 R2 other group untouched", rf[oa], pre[oa]);
        for (int k = 0; k < 16; k++) pre[k] = rf[k];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !rf_we && !mem_re, "R10 reset outputs", {13'd0, done, rf_we, mem_re}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rf_we && !mem_re, "R10 idle after reset", {13'd0, done, rf_we, mem_re}, 16'd0);
        for (int i = 0; i < 128; i++) begin
            preload(i);
            run_instr(i[6], i[2:0], i[4:3], i[5], (i % 3) == 1);
        end
        // R4 wrap: address register at 0xFFFF
        preload(7);
        @(negedge clk); pl_we = 1'b1; pl_idx = 4'd2; pl_data = 16'hFFFF; pre[2] = 16'hFFFF;
        @(negedge clk); pl_we = 1'b0;
        run_instr(1'b0, 3'd2, 2'd2, 1'b0, 1'b0);
        chk(pre[2] == 16'h0000, "R4 wrap to zero", pre[2], 16'h0000);
        // R7 same register, carry into the high byte
        @(negedge clk); pl_we = 1'b1; pl_idx = 4'd13; pl_data = 16'h12FF; pre[13] = 16'h12FF;
        @(negedge clk); pl_we = 1'b0;
        run_instr(1'b1, 3'd5, 2'd2, 1'b1, 1'b0);
        chk(pre[13][15:8] == 8'h13, "R7 incremented high byte kept", {8'h0, pre[13][15:8]}, 16'h0013);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule